// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative holding area placed next to a direct-mapped cache with 32-byte lines. Each line that the main cache throws out on a refill is handed to the buffer through the insert port, together with its block address, which is the byte address with the 5 offset bits removed. The buffer keeps a few such lines, four by default. Each entry has its own comparator, and all entries are searched in parallel.

The main cache asks the buffer only after it has missed. It drives the lookup port with the full block address. Within the same cycle the block reports whether it holds that block and, if it does, returns the stored line. A lookup by itself changes nothing. To take the line, the requester also raises the swap strobe in that cycle. At the next clock edge the matching entry is then overwritten by the line the main cache displaces, which completes the exchange. If the main cache had no valid line to give up, the entry is freed instead. A lookup miss means the request goes on to the next level of memory.

When the buffer is full, a new insertion overwrites the entry that was least recently written, counting both insertions and swaps. Free entries are always used before any occupied entry is overwritten.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is empty, so a lookup of any block address misses.
- R2: After a line is inserted under a block address, a lookup of that same address hits in the same cycle and returns exactly that line.
- R3: A lookup matches only on the whole block address. An address that differs in any bit misses. This includes an address that maps to the same main-cache set (block address bits 6:0 for 128 sets) but has a different tag above bit 6.
- R4: `lk_hit` is low whenever `lk_valid` is low, and `lk_line` is all zeros whenever `lk_hit` is low.
- R5: Up to ENTRIES lines with distinct block addresses are held at the same time, and each one can be found.
- R6: An insertion into a full buffer overwrites the entry whose last write (by insert or by swap) is the oldest. The other entries are unaffected.
- R7: When `sw_en` and `sw_fill` are high during a lookup hit, the hit entry is replaced at the clock edge by `sw_blk`/`sw_line`. Afterwards the old address misses and the new one hits.
- R8: When `sw_en` is high and `sw_fill` is low during a lookup hit, the hit entry is freed. The next insertion uses that free entry and overwrites no other line.
- R9: A swapped-in line counts as the most recently written entry, so later insertions overwrite it last.
- R10: A lookup without a swap changes neither the contents nor the replacement order. In particular, a hit that is only probed does not protect that entry from being overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Write an evicted line into the buffer at this edge |
| ins_blk | input | BLK_W (27) | Block address of the evicted line |
| ins_line | input | LINE_W (256) | Data of the evicted line |
| lk_valid | input | 1 | Lookup request |
| lk_blk | input | BLK_W (27) | Block address to search for |
| lk_hit | output | 1 | Lookup found the address (combinational) |
| lk_line | output | LINE_W (256) | Line of the hit entry, zero on a miss |
| sw_en | input | 1 | Take the hit line and update the entry at this edge |
| sw_fill | input | 1 | The main cache supplies a displaced line for the freed entry |
| sw_blk | input | BLK_W (27) | Block address of the displaced main-cache line |
| sw_line | input | LINE_W (256) | Data of the displaced main-cache line |

## Verification
The checker assumes that the main cache never inserts and looks up in the same cycle, and that it raises `sw_en` only while its lookup hits. It also assumes that no block address is ever present twice, which follows from the fact that only lines just evicted from the main cache are inserted. The single-match and occupancy properties rely on these assumptions. The directed stimulus keeps to them: each insert, probe or swap takes its own clock cycle, every swap targets an address that is known to be held, and every inserted or swapped-in address is new to the buffer.

// File: rtl/vc_pkg.sv
// Shared types for the victim line buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package vc_pkg;

    // Single state-changing action the buffer carries out at one clock edge.
    typedef enum logic [1:0] {
        OP_IDLE      = 2'd0,
        OP_INSERT    = 2'd1,
        OP_SWAP_FILL = 2'd2,
        OP_SWAP_DROP = 2'd3
    } vc_op_e;

endpackage

// File: rtl/vc_store.sv
// Entry storage: valid bit, block address and line data for each entry.
// Assumes that a write and a clear never target the same entry in one cycle.
module vc_store #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 27,
    parameter int LINE_W  = 256,
    parameter int IDX_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [BLK_W-1:0]                 wr_blk,
    input  logic [LINE_W-1:0]                wr_line,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    output logic [ENTRIES-1:0]               valid_o,
    output logic [ENTRIES-1:0][BLK_W-1:0]    blk_o,
    output logic [ENTRIES-1:0][LINE_W-1:0]   line_o
);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][BLK_W-1:0]  blk_q;
    logic [ENTRIES-1:0][LINE_W-1:0] line_q;

    // Valid bits: set by a write, cleared by a drop, all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_en && wr_idx == IDX_W'(e)) begin
                    valid_q[e] <= 1'b1;
                end else if (clr_en && clr_idx == IDX_W'(e)) begin
                    valid_q[e] <= 1'b0;
                end
            end
        end
    end

    // Address and data payload of each entry, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            line_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_en && wr_idx == IDX_W'(e)) begin
                    blk_q[e]  <= wr_blk;
                    line_q[e] <= wr_line;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign blk_o   = blk_q;
    assign line_o  = line_q;

endmodule

// File: rtl/vc_match.sv
// Parallel search: one comparator per entry on the full block address,
// followed by an AND-OR selection of the line held by the matching entry.
// Assumes that at most one valid entry holds a given block address.
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 27,
    parameter int LINE_W  = 256,
    parameter int IDX_W   = 2
) (
    input  logic                             req,
    input  logic [BLK_W-1:0]                 key,
    input  logic [ENTRIES-1:0]               valid_i,
    input  logic [ENTRIES-1:0][BLK_W-1:0]    blk_i,
    input  logic [ENTRIES-1:0][LINE_W-1:0]   line_i,
    output logic [ENTRIES-1:0]               hit_vec_o,
    output logic                             hit_o,
    output logic [IDX_W-1:0]                 hit_idx_o,
    output logic [LINE_W-1:0]                line_o
);

    // One comparator for each entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec_o[g] = req && valid_i[g] && (blk_i[g] == key);
    end

    assign hit_o = |hit_vec_o;

    // Encode the matching entry into an index.
    always_comb begin
        hit_idx_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec_o[e]) hit_idx_o = IDX_W'(e);
        end
    end

    // AND-OR line selection; the result is zero when nothing matches.
    always_comb begin
        line_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec_o[e]) line_o = line_o | line_i[e];
        end
    end

endmodule

// File: rtl/vc_age.sv
// Replacement order: each entry carries a rank, 0 for the newest write and
// ENTRIES-1 for the oldest. The ranks always form a permutation. A write
// moves an entry to rank 0, and a drop moves it to the oldest rank. The slot
// chosen for a new insertion is the lowest free entry, or the oldest entry
// when none is free. Assumes touch and demote are never asserted together.
module vc_age #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               demote_en,
    input  logic [IDX_W-1:0]   demote_idx,
    input  logic [ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]   vic_idx_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic                          free_found;

    // Rank update: reset gives distinct ranks, a touch promotes, a demote retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) age_q[e] <= IDX_W'(e);
        end else if (touch_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (IDX_W'(e) == touch_idx) begin
                    age_q[e] <= '0;
                end else if (age_q[e] < age_q[touch_idx]) begin
                    age_q[e] <= age_q[e] + 1'b1;
                end
            end
        end else if (demote_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (IDX_W'(e) == demote_idx) begin
                    age_q[e] <= OLDEST;
                end else if (age_q[e] > age_q[demote_idx]) begin
                    age_q[e] <= age_q[e] - 1'b1;
                end
            end
        end
    end

    // Slot choice: lowest free entry first, otherwise the oldest rank.
    always_comb begin
        vic_idx_o  = '0;
        free_found = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!free_found && !valid_i[e]) begin
                vic_idx_o  = IDX_W'(e);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (age_q[e] == OLDEST) vic_idx_o = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/victim_cache.sv
// Victim line buffer placed beside a direct-mapped cache. Lines evicted from
// the cache are inserted here. After a main-cache miss, a lookup searches
// every entry in parallel by full block address. On a hit the line is
// returned in the same cycle, and a swap replaces it with the line the cache
// displaces, or frees the entry when the cache has no line to give up.
// Assumes: insert and lookup never overlap, sw_en only with a lookup hit,
// and no block address is inserted while it is already held.
module victim_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int ENTRIES    = 4,
    localparam int OFFSET_W  = $clog2(LINE_BYTES),
    localparam int BLK_W     = ADDR_W - OFFSET_W,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [BLK_W-1:0]  ins_blk,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              lk_valid,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line,
    input  logic              sw_en,
    input  logic              sw_fill,
    input  logic [BLK_W-1:0]  sw_blk,
    input  logic [LINE_W-1:0] sw_line
);

    import vc_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             entry_valid;
    logic [ENTRIES-1:0][BLK_W-1:0]  entry_blk;
    logic [ENTRIES-1:0][LINE_W-1:0] entry_line;
    logic [ENTRIES-1:0]             match_vec;
    logic [IDX_W-1:0]               match_idx;
    logic [IDX_W-1:0]               vic_idx;
    vc_op_e                         op;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BLK_W-1:0]  wr_blk;
    logic [LINE_W-1:0] wr_line;
    logic              drop_en;

    // Parallel tag search over all entries.
    vc_match #(
        .ENTRIES(ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
    ) u_match (
        .req       (lk_valid),
        .key       (lk_blk),
        .valid_i   (entry_valid),
        .blk_i     (entry_blk),
        .line_i    (entry_line),
        .hit_vec_o (match_vec),
        .hit_o     (lk_hit),
        .hit_idx_o (match_idx),
        .line_o    (lk_line)
    );

    // Choose the single action for this edge; insertion takes precedence.
    always_comb begin
        op = OP_IDLE;
        if (ins_valid) begin
            op = OP_INSERT;
        end else if (sw_en && lk_hit) begin
            op = sw_fill ? OP_SWAP_FILL : OP_SWAP_DROP;
        end
    end

    // Route the write port from either the insert or the swap side.
    always_comb begin
        wr_en   = (op == OP_INSERT) || (op == OP_SWAP_FILL);
        drop_en = (op == OP_SWAP_DROP);
        if (op == OP_INSERT) begin
            wr_idx  = vic_idx;
            wr_blk  = ins_blk;
            wr_line = ins_line;
        end else begin
            wr_idx  = match_idx;
            wr_blk  = sw_blk;
            wr_line = sw_line;
        end
    end

    // Entry registers.
    vc_store #(
        .ENTRIES(ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_blk  (wr_blk),
        .wr_line (wr_line),
        .clr_en  (drop_en),
        .clr_idx (match_idx),
        .valid_o (entry_valid),
        .blk_o   (entry_blk),
        .line_o  (entry_line)
    );

    // Replacement order and slot selection.
    vc_age #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (wr_en),
        .touch_idx  (wr_idx),
        .demote_en  (drop_en),
        .demote_idx (match_idx),
        .valid_i    (entry_valid),
        .vic_idx_o  (vic_idx)
    );

endmodule

// File: rtl/victim_cache_chk.sv
// Property checker for the victim line buffer, attached through bind.
// It observes the ports plus the entry valid bits and the comparator outputs.
module victim_cache_chk #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [LINE_W-1:0]  lk_line,
    input logic               sw_en,
    input logic               sw_fill,
    input logic [ENTRIES-1:0] entry_valid,
    input logic [ENTRIES-1:0] match_vec
);

    // Input assumption: insert and lookup never share a cycle.
    a_in_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_valid && lk_valid));

    // Input assumption: a swap is requested only while the lookup hits.
    a_in_swap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> lk_hit);

    // R1: leaving reset with every entry empty.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (entry_valid == '0));

    // R4: no hit without a request.
    a_r4_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R4: the returned line is zero on a miss.
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_line == '0));

    // R5: at most one entry matches any address.
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R2: insertion into a buffer with space adds exactly one entry.
    a_r2_insert_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !(&entry_valid)) |=>
            ($countones(entry_valid) == $countones($past(entry_valid)) + 1));

    // R6: insertion into a full buffer overwrites and keeps it full.
    a_r6_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (&entry_valid)) |=> (&entry_valid));

    // R7: a swap with a displaced line keeps the hit entry occupied.
    a_r7_fill_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && sw_en && sw_fill && !ins_valid) |=>
            ((entry_valid & $past(match_vec)) == $past(match_vec)));

    // R8: a swap without a displaced line frees the hit entry.
    a_r8_drop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && sw_en && !sw_fill && !ins_valid) |=>
            ((entry_valid & $past(match_vec)) == '0));

    // R10: a cycle with neither insert nor swap leaves occupancy unchanged.
    a_r10_probe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !(sw_en && lk_hit)) |=> $stable(entry_valid));

endmodule

bind victim_cache victim_cache_chk #(
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .lk_valid    (lk_valid),
    .lk_hit      (lk_hit),
    .lk_line     (lk_line),
    .sw_en       (sw_en),
    .sw_fill     (sw_fill),
    .entry_valid (entry_valid),
    .match_vec   (match_vec)
);

// File: tb/victim_cache_test.sv
// Directed bench for the victim line buffer: one task per scenario.
module victim_cache_test;

    localparam int BW = 27;
    localparam int LW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [BW-1:0] ins_blk = '0;
    logic [LW-1:0] ins_line = '0;
    logic          lk_valid = 1'b0;
    logic [BW-1:0] lk_blk = '0;
    logic          lk_hit;
    logic [LW-1:0] lk_line;
    logic          sw_en = 1'b0;
    logic          sw_fill = 1'b0;
    logic [BW-1:0] sw_blk = '0;
    logic [LW-1:0] sw_line = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Block addresses; bits 6:0 would be the main-cache set index.
    localparam logic [BW-1:0] A = 27'h0012345;
    localparam logic [BW-1:0] B = 27'h0012346;
    localparam logic [BW-1:0] C = 27'h0200045;
    localparam logic [BW-1:0] D = 27'h0300045;
    localparam logic [BW-1:0] E = 27'h0400045;
    localparam logic [BW-1:0] F = 27'h0500101;
    localparam logic [BW-1:0] G = 27'h0600045;
    localparam logic [BW-1:0] H = 27'h0700045;
    localparam logic [BW-1:0] I = 27'h0000045;

    always #4 clk = ~clk;

    victim_cache uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_blk(ins_blk), .ins_line(ins_line),
        .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_hit(lk_hit), .lk_line(lk_line),
        .sw_en(sw_en), .sw_fill(sw_fill), .sw_blk(sw_blk), .sw_line(sw_line)
    );

    function automatic logic [LW-1:0] mk(input int seed);
        logic [LW-1:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = 32'(seed * 256 + w) ^ 32'hC3A5_0000;
        return l;
    endfunction

    task automatic chk(input logic [LW-1:0] act, input logic [LW-1:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_insert(input logic [BW-1:0] blk, input logic [LW-1:0] line);
        @(negedge clk);
        ins_valid = 1'b1; ins_blk = blk; ins_line = line;
        @(posedge clk); #1;
        ins_valid = 1'b0;
    endtask

    // Probe between edges, without a swap, so no state can change.
    task automatic probe(input logic [BW-1:0] blk, input bit exp_hit,
                         input logic [LW-1:0] exp_line, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_blk = blk;
        #1;
        chk(LW'(lk_hit), LW'(exp_hit), req, $sformatf("hit for %h", blk));
        chk(lk_line, exp_hit ? exp_line : '0, req, $sformatf("line for %h", blk));
        #1 lk_valid = 1'b0;
    endtask

    task automatic do_swap(input logic [BW-1:0] blk, input logic [LW-1:0] exp_line,
                           input bit fill, input logic [BW-1:0] nblk,
                           input logic [LW-1:0] nline, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_blk = blk;
        sw_en = 1'b1; sw_fill = fill; sw_blk = nblk; sw_line = nline;
        #1;
        chk(LW'(lk_hit), LW'(1), req, "swap hit");
        chk(lk_line, exp_line, req, "swap line");
        @(posedge clk); #1;
        lk_valid = 1'b0; sw_en = 1'b0; sw_fill = 1'b0;
    endtask

    task automatic t_reset();
        probe(A, 1'b0, '0, "R1");
        probe(27'h0, 1'b0, '0, "R1");
        probe(27'h7FFFFFF, 1'b0, '0, "R4");
    endtask

    task automatic t_fill();
        do_insert(A, mk(1));
        do_insert(B, mk(2));
        do_insert(C, mk(3));
        do_insert(D, mk(4));
        probe(A, 1'b1, mk(1), "R2");
        probe(B, 1'b1, mk(2), "R5");
        probe(C, 1'b1, mk(3), "R5");
        probe(D, 1'b1, mk(4), "R5");
        // R4: a held address without a request does not hit
        @(negedge clk);
        lk_valid = 1'b0; lk_blk = A;
        #1;
        chk(LW'(lk_hit), '0, "R4", "idle hit");
        chk(lk_line, '0, "R4", "idle line");
    endtask

    task automatic t_alias();
        probe(A ^ 27'h80, 1'b0, '0, "R3");
        probe(A ^ 27'h1, 1'b0, '0, "R3");
        probe(A ^ 27'h4000000, 1'b0, '0, "R3");
        probe(A, 1'b1, mk(1), "R3");
    endtask

    task automatic t_evict();
        do_insert(E, mk(5));
        probe(A, 1'b0, '0, "R6");
        probe(B, 1'b1, mk(2), "R6");
        probe(C, 1'b1, mk(3), "R6");
        probe(D, 1'b1, mk(4), "R6");
        probe(E, 1'b1, mk(5), "R6");
    endtask

    task automatic t_swap();
        do_swap(B, mk(2), 1'b1, F, mk(6), "R7");
        probe(B, 1'b0, '0, "R7");
        probe(F, 1'b1, mk(6), "R7");
        do_insert(G, mk(7));
        probe(C, 1'b0, '0, "R9");
        probe(F, 1'b1, mk(6), "R9");
        probe(D, 1'b1, mk(4), "R9");
        probe(G, 1'b1, mk(7), "R9");
    endtask

    task automatic t_drop();
        do_swap(D, mk(4), 1'b0, '0, '0, "R8");
        probe(D, 1'b0, '0, "R8");
        do_insert(H, mk(8));
        probe(E, 1'b1, mk(5), "R8");
        probe(F, 1'b1, mk(6), "R8");
        probe(G, 1'b1, mk(7), "R8");
        probe(H, 1'b1, mk(8), "R8");
    endtask

    task automatic t_probe_no_effect();
        probe(E, 1'b1, mk(5), "R10");
        probe(E, 1'b1, mk(5), "R10");
        do_insert(I, mk(9));
        probe(E, 1'b0, '0, "R10");
        probe(F, 1'b1, mk(6), "R10");
        probe(H, 1'b1, mk(8), "R10");
        probe(I, 1'b1, mk(9), "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_alias();
        t_evict();
        t_swap();
        t_drop();
        t_probe_no_effect();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule